// File: doc/BRIEF.md
# Packed SIMD Lane Adder

This unit adds or subtracts two 64-bit packed operands lane by lane. A lane size input splits each operand into eight 8-bit, four 16-bit, two 32-bit or one 64-bit element. Lane 0 always sits at the least significant end. Each lane is computed on its own, and no carry passes between neighbouring lanes.

A mode field picks one of four result forms: wrapping, saturating, halving, or rounded halving. A signedness bit sets how the elements are read. A start pulse loads the result into an output register, and a valid strobe follows one cycle later. A sticky flag records that some lane clipped during a saturating operation. It stays set until a clear input drops it.

Top module: `simd_lane_adder`

## Requirements
- R1: `lane_sz` selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies bits [k*w+w-1 : k*w], so lane 0 is at the least significant end.
- R2: No carry or borrow crosses a lane boundary. In wrapping mode, 8-bit lanes of all ones plus 0x01 in every lane give zero in every lane.
- R3: With `mode` = 0 (wrap), each lane result is (a + b) or (a - b) modulo 2^w, where `op_sub` = 1 selects subtraction.
- R4: With `mode` = 1 (saturate) and `is_signed` = 1, a lane result outside [-2^(w-1), 2^(w-1)-1] is replaced by the nearer limit.
- R5: With `mode` = 1 and `is_signed` = 0, a sum above 2^w-1 gives all ones, and a difference below 0 gives 0.
- R6: With `mode` = 2 (halve), each lane gives floor((a ± b) / 2). The sum or difference is formed exactly before the shift, and the low w bits are kept.
- R7: With `mode` = 3 (rounded halve), each lane gives floor((a ± b + 1) / 2), keeping the low w bits.
- R8: `sat_flag` rises in the cycle a saturating result is loaded in which any lane clipped. It then stays set through later operations of any kind.
- R9: A high `flag_clr` leaves `sat_flag` at 0 on the next cycle, even when a clipping operation is loaded in the same cycle.
- R10: `result` and `valid` reset to 0. A `start` pulse loads `result` and raises `valid` for exactly the next cycle. Without `start`, `result` holds.
- R11: Wrapping, halving and rounded-halving operations never set `sat_flag`, even when they overflow.
- R12: With 16-bit unsigned add, lanes {0x1001,0x1234,0x0007,0x00AB} plus {0x0FF0,0x5678,0xFFF8,0x00CD} (lane 3 down to lane 0) give {0x1FF1,0x68AC,0xFFFF,0x0178}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Loads the computed result this cycle |
| op_sub | input | 1 | 1 subtracts b from a, 0 adds |
| mode | input | 2 | 0 wrap, 1 saturate, 2 halve, 3 rounded halve |
| is_signed | input | 1 | 1 treats lanes as two's complement |
| lane_sz | input | 2 | Element width select: 8, 16, 32, 64 bits |
| opa | input | 64 | Packed operand a |
| opb | input | 64 | Packed operand b |
| flag_clr | input | 1 | Clears the saturation flag; wins over a set |
| result | output | 64 | Registered packed result |
| valid | output | 1 | High for one cycle after start |
| sat_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
The assertions assume that `start` and `flag_clr` are single-cycle, synchronous controls. They also assume that `mode` is stable in the cycle it is sampled with `start`, so a rising flag can be traced back to a saturating load. The stimulus drives every input on the falling clock edge and holds each control high for one cycle only. The flag is cleared only through `flag_clr`, and the bench's flag model follows the same rule.

// File: rtl/simd_lane_adder.sv
module simd_lane_adder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_sub,
  input  logic [1:0]  mode,
  input  logic        is_signed,
  input  logic [1:0]  lane_sz,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  input  logic        flag_clr,
  output logic [63:0] result,
  output logic        valid,
  output logic        sat_flag
);
  localparam int DW = 64;
  localparam int NSZ = 4;

  logic [NSZ-1:0][DW-1:0] res_w;
  logic [NSZ-1:0]         clip_w;

  for (genvar k = 0; k < NSZ; k++) begin : g_sz
    localparam int W  = 8 << k;
    localparam int NL = DW / W;
    logic [NL-1:0] ovf_l;
    for (genvar j = 0; j < NL; j++) begin : g_lane
      logic [W-1:0] a, b, clip;
      logic [W:0]   ax, bx, s, r;
      logic         ovf;
      assign a  = opa[j*W +: W];
      assign b  = opb[j*W +: W];
      assign ax = {is_signed & a[W-1], a};
      assign bx = {is_signed & b[W-1], b};
      assign s  = op_sub ? ax - bx : ax + bx;
      assign r  = s + 1'b1;
      assign ovf = is_signed ? (s[W] ^ s[W-1]) : s[W];
      assign clip = is_signed ? (s[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                              : (op_sub ? {W{1'b0}} : {W{1'b1}});
      assign ovf_l[j] = (mode == 2'd1) & ovf;
      assign res_w[k][j*W +: W] = (mode == 2'd0) ? s[W-1:0] :
                                  (mode == 2'd1) ? (ovf ? clip : s[W-1:0]) :
                                  (mode == 2'd2) ? s[W:1] : r[W:1];
    end
    assign clip_w[k] = |ovf_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= start;
      if (start) result <= res_w[lane_sz];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           sat_flag <= 1'b0;
    else if (flag_clr)                    sat_flag <= 1'b0;
    else if (start && clip_w[lane_sz])    sat_flag <= 1'b1;
  end
endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  mode,
  input logic        flag_clr,
  input logic [63:0] result,
  input logic        valid,
  input logic        sat_flag
);
  p_valid_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);
  p_valid_needs_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);
  p_result_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !flag_clr) |=> sat_flag);
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !sat_flag);
  p_no_flag_nonsat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_flag && !(start && mode == 2'd1)) |=> !sat_flag);
endmodule

bind simd_lane_adder simd_lane_adder_chk u_chk (.*);

// File: tb/simd_lane_adder_bench.sv
module simd_lane_adder_bench;
  logic clk = 0, rst_n = 0;
  logic start = 0, op_sub = 0, is_signed = 0, flag_clr = 0;
  logic [1:0] mode = 0, lane_sz = 0;
  logic [63:0] opa = 0, opb = 0;
  logic [63:0] result;
  logic valid, sat_flag;
  int n_chk = 0, n_fail = 0;
  logic flag_m = 0;

  always #10 clk = ~clk;

  simd_lane_adder u_simd_lane_adder (.*);

  function automatic logic [64:0] ref_op(logic [63:0] a, logic [63:0] b, logic sub,
                                         logic [1:0] md, logic sg, logic [1:0] sz);
    int w = 8 << sz;
    logic [63:0] res = 0;
    logic sat = 0;
    for (int i = 0; i < 64 / w; i++) begin
      logic signed [67:0] ea = 0, eb = 0, v, hi, lo;
      for (int t = 0; t < 68; t++) begin
        ea[t] = (t < w) ? a[i*w+t] : (sg & a[i*w+w-1]);
        eb[t] = (t < w) ? b[i*w+t] : (sg & b[i*w+w-1]);
      end
      v = sub ? ea - eb : ea + eb;
      hi = sg ? (68'sd1 <<< (w-1)) - 1 : (68'sd1 <<< w) - 1;
      lo = sg ? -(68'sd1 <<< (w-1)) : 68'sd0;
      case (md)
        2'd1: begin
          if (v > hi) begin v = hi; sat = 1; end
          else if (v < lo) begin v = lo; sat = 1; end
        end
        2'd2: v = v >>> 1;
        2'd3: v = (v + 1) >>> 1;
        default: ;
      endcase
      for (int t = 0; t < w; t++) res[i*w+t] = v[t];
    end
    return {sat, res};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [63:0] a, logic [63:0] b, logic sub,
                     logic [1:0] md, logic sg, logic [1:0] sz, logic clr);
    logic [64:0] e = ref_op(a, b, sub, md, sg, sz);
    @(negedge clk);
    opa = a; opb = b; op_sub = sub; mode = md; is_signed = sg; lane_sz = sz;
    start = 1; flag_clr = clr;
    @(negedge clk);
    start = 0; flag_clr = 0;
    flag_m = clr ? 1'b0 : (flag_m | e[64]);
    chk(req, result, e[63:0]);
    chk({req, " valid"}, {63'd0, valid}, 64'd1);
    chk({req, " flag"}, {63'd0, sat_flag}, {63'd0, flag_m});
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    #35;
    chk("R10 reset result", result, 64'd0);
    chk("R10 reset valid", {63'd0, valid}, 64'd0);
    chk("R8 reset flag", {63'd0, sat_flag}, 64'd0);
    rst_n = 1;

    run("R12", 64'h1001_1234_0007_00AB, 64'h0FF0_5678_FFF8_00CD, 0, 0, 0, 1, 0);
    chk("R12 literal", result, 64'h1FF1_68AC_FFFF_0178);
    run("R2", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 0, 0, 0);
    chk("R2 literal", result, 64'd0);
    run("R1 lane order", 64'h0000_0003_0000_0001, 64'h0000_0001_0000_0001, 0, 0, 0, 2, 0);
    chk("R1 literal", result, 64'h0000_0004_0000_0002);
    run("R3 wrap sub", 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 1, 0, 0, 3, 0);
    chk("R3 literal", result, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R11 wrap overflow", 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 0, 0, 1, 0, 0);
    run("R11 halve", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2, 0, 3, 0);
    chk("R6 literal", result, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R7 round", 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 0, 3, 0, 3, 0);
    chk("R7 literal", result, 64'd2);
    run("R6 signed halve", 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_00FE, 0, 2, 1, 0, 0);
    chk("R6 signed literal", result[7:0], 64'hFE);
    run("R4 signed clip", 64'h0000_0000_0000_007F, 64'h0000_0000_0000_0001, 0, 1, 1, 0, 0);
    chk("R4 literal", result[7:0], 64'h7F);
    chk("R8 set", {63'd0, sat_flag}, 64'd1);
    run("R8 sticky", 64'd5, 64'd6, 0, 0, 0, 1, 0);
    chk("R8 sticky literal", {63'd0, sat_flag}, 64'd1);
    run("R9 clear wins", 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 1, 1, 0, 0, 1);
    chk("R5 underflow literal", result, 64'd0);
    chk("R9 literal", {63'd0, sat_flag}, 64'd0);
    run("R5 unsigned clip", 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, 0, 1, 0, 2, 0);
    chk("R5 literal", result, 64'hFFFF_FFFF_0000_0002);
    run("R4 min clip", 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 1, 1, 1, 3, 0);
    chk("R4 min literal", result, 64'h8000_0000_0000_0000);
    @(negedge clk);
    chk("R10 valid drops", {63'd0, valid}, 64'd0);
    chk("R10 result holds", result, 64'h8000_0000_0000_0000);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0; flag_m = 0;
    chk("R9 plain clear", {63'd0, sat_flag}, 64'd0);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] md = 2'($urandom);
      string req = (md == 0) ? "R3" : (md == 1) ? "R4/R5" : (md == 2) ? "R6" : "R7";
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      if (n % 7 == 0) b = ~a;
      run(req, a, b, 1'($urandom), md, 1'($urandom), 2'($urandom), ($urandom % 9) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule